// File: doc/BRIEF.md
# Tamper Event Timestamp Capture

This block records when a tamper event happened. The calendar counter next to it supplies six BCD fields: seconds, minutes, hours, day, month and year. A tamper pulse arrives already synchronized to the clock. On that pulse the block copies all six fields into its capture registers on one clock edge. It also sets two event flags and, if enabled, pulls an active-low interrupt.

Software reaches the block through a byte-wide register port with a synchronous write and a combinational read. Through it software picks one of two retention policies, or switches the function off, and then reads the stored time. It clears the flags by writing zeros to them. One policy keeps the newest event. The other keeps the first event and holds it until software has cleared both flags.

Top module: `tamper_stamp`

## Requirements
- R1: After reset every register reads 0x00 and `irq_n` is high.
- R2: A tamper pulse that is accepted stores all six calendar fields on the same clock edge. They read back zero-extended: seconds at address 3, minutes at 4, hours at 5, day at 6, month at 7 and year at 8.
- R3: An accepted event sets flag A (address 0, bit 4) and flag B (address 1, bit 5).
- R4: When the retention bit (address 2, bit 7) is 0, every tamper pulse is accepted and overwrites the previous capture.
- R5: When the retention bit is 1, a tamper pulse is ignored while either flag is set. No capture is made and no flag changes. Once both flags are clear, the next pulse is accepted.
- R6: When the off bit (address 2, bit 6) is 1, tamper pulses neither capture nor set any flag.
- R7: Writing 0 to a flag bit clears that flag, and writing 1 leaves it unchanged. If an accepted event falls in the same cycle as a clearing write, the event wins and the flag ends up set.
- R8: `irq_n` is low exactly when the interrupt enable (address 1, bit 2) is 1 and at least one flag is set.
- R9: Writes to addresses 3 to 8 have no effect. Bits that are not defined, and addresses above 8, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tamper | input | 1 | Synchronized tamper pulse, one cycle wide |
| cal_sec | input | 7 | Current seconds, BCD |
| cal_min | input | 7 | Current minutes, BCD |
| cal_hour | input | 6 | Current hours, BCD |
| cal_day | input | 6 | Current day of month, BCD |
| cal_mon | input | 5 | Current month 1 to 12, BCD |
| cal_year | input | 8 | Current year, BCD |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr` |
| irq_n | output | 1 | Active-low timestamp interrupt |

## Verification
A table of events is applied in sequence. It mixes calendar values at rollover edges with mid-range values, and it changes the retention and off bits between events. Each readback tells a fresh capture apart from a held one. Directed cases then cover the following:
- clearing only one flag while retention is set, which must still block capture;
- a clearing write that coincides with an event;
- writes of 1 to a flag;
- writes to the capture addresses.

These show the arbitration between flag clearing and event acceptance, which the table alone does not resolve.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;

    localparam int ADDR_CTL_A  = 0;
    localparam int ADDR_CTL_B  = 1;
    localparam int ADDR_MODE   = 2;
    localparam int ADDR_FIELD0 = 3;
    localparam int NUM_FIELDS  = 6;

    localparam int BIT_FLAG_A  = 4;
    localparam int BIT_FLAG_B  = 5;
    localparam int BIT_IE      = 2;
    localparam int BIT_OFF     = 6;
    localparam int BIT_KEEP    = 7;

    typedef struct packed {
        logic keep;
        logic off;
        logic ie;
        logic flag_a;
        logic flag_b;
    } ctrl_state_t;

endpackage

// File: rtl/tstamp_ctrl.sv
module tstamp_ctrl
    import tstamp_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tamper,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_state_t       state,
    output logic              capture_en,
    output logic              irq_n
);

    ctrl_state_t state_d, state_q;
    logic        take_d;
    wire         unused_wdata = ^wdata;

    always_comb begin
        state_d = state_q;
        // accept an event unless switched off or holding a first event
        take_d  = tamper && !state_q.off &&
                  (!state_q.keep || (!state_q.flag_a && !state_q.flag_b));

        if (wr_en) begin
            if (addr == ADDR_W'(ADDR_MODE)) begin
                state_d.keep = wdata[BIT_KEEP];
                state_d.off  = wdata[BIT_OFF];
            end
            if (addr == ADDR_W'(ADDR_CTL_B)) begin
                state_d.ie = wdata[BIT_IE];
                if (!wdata[BIT_FLAG_B]) state_d.flag_b = 1'b0;
            end
            if (addr == ADDR_W'(ADDR_CTL_A)) begin
                if (!wdata[BIT_FLAG_A]) state_d.flag_a = 1'b0;
            end
        end

        // an accepted event overrides a clearing write in the same cycle
        if (take_d) begin
            state_d.flag_a = 1'b1;
            state_d.flag_b = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign state      = state_q;
    assign capture_en = take_d;
    assign irq_n      = !(state_q.ie && (state_q.flag_a || state_q.flag_b));

endmodule

// File: rtl/tstamp_capture.sv
module tstamp_capture #(
    parameter int TS_W = 39
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture_en,
    input  logic [TS_W-1:0] cal_in,
    output logic [TS_W-1:0] stamp
);

    logic [TS_W-1:0] stamp_d, stamp_q;

    always_comb begin
        stamp_d = stamp_q;
        // whole vector in one edge: no field mixes two calendar states
        if (capture_en) stamp_d = cal_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stamp_q <= '0;
        else        stamp_q <= stamp_d;
    end

    assign stamp = stamp_q;

endmodule

// File: rtl/tstamp_rdmux.sv
module tstamp_rdmux
    import tstamp_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int SEC_W  = 7,
    parameter int MIN_W  = 7,
    parameter int HR_W   = 6,
    parameter int DAY_W  = 6,
    parameter int MON_W  = 5,
    parameter int YR_W   = 8,
    localparam int TS_W  = SEC_W + MIN_W + HR_W + DAY_W + MON_W + YR_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  ctrl_state_t       state,
    input  logic [TS_W-1:0]   stamp,
    output logic [DATA_W-1:0] rdata
);

    localparam int LO_MIN = SEC_W;
    localparam int LO_HR  = LO_MIN + MIN_W;
    localparam int LO_DAY = LO_HR + HR_W;
    localparam int LO_MON = LO_DAY + DAY_W;
    localparam int LO_YR  = LO_MON + MON_W;

    logic [DATA_W-1:0] field_byte [NUM_FIELDS];

    always_comb begin
        for (int i = 0; i < NUM_FIELDS; i++) field_byte[i] = '0;
        field_byte[0][SEC_W-1:0] = stamp[SEC_W-1:0];
        field_byte[1][MIN_W-1:0] = stamp[LO_MIN +: MIN_W];
        field_byte[2][HR_W-1:0]  = stamp[LO_HR  +: HR_W];
        field_byte[3][DAY_W-1:0] = stamp[LO_DAY +: DAY_W];
        field_byte[4][MON_W-1:0] = stamp[LO_MON +: MON_W];
        field_byte[5][YR_W-1:0]  = stamp[LO_YR  +: YR_W];
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADDR_CTL_A)) begin
            rdata[BIT_FLAG_A] = state.flag_a;
        end else if (addr == ADDR_W'(ADDR_CTL_B)) begin
            rdata[BIT_FLAG_B] = state.flag_b;
            rdata[BIT_IE]     = state.ie;
        end else if (addr == ADDR_W'(ADDR_MODE)) begin
            rdata[BIT_KEEP] = state.keep;
            rdata[BIT_OFF]  = state.off;
        end else begin
            for (int i = 0; i < NUM_FIELDS; i++) begin
                if (addr == ADDR_W'(ADDR_FIELD0 + i)) rdata = field_byte[i];
            end
        end
    end

endmodule

// File: rtl/tamper_stamp.sv
module tamper_stamp
    import tstamp_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int SEC_W  = 7,
    parameter int MIN_W  = 7,
    parameter int HR_W   = 6,
    parameter int DAY_W  = 6,
    parameter int MON_W  = 5,
    parameter int YR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tamper,
    input  logic [SEC_W-1:0]  cal_sec,
    input  logic [MIN_W-1:0]  cal_min,
    input  logic [HR_W-1:0]   cal_hour,
    input  logic [DAY_W-1:0]  cal_day,
    input  logic [MON_W-1:0]  cal_mon,
    input  logic [YR_W-1:0]   cal_year,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_n
);

    localparam int TS_W = SEC_W + MIN_W + HR_W + DAY_W + MON_W + YR_W;

    ctrl_state_t     ctrl_q;
    logic            capture_en;
    logic [TS_W-1:0] cal_vec;
    logic [TS_W-1:0] stamp_q;

    assign cal_vec = {cal_year, cal_mon, cal_day, cal_hour, cal_min, cal_sec};

    tstamp_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tamper     (tamper),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .state      (ctrl_q),
        .capture_en (capture_en),
        .irq_n      (irq_n)
    );

    tstamp_capture #(.TS_W(TS_W)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_en (capture_en),
        .cal_in     (cal_vec),
        .stamp      (stamp_q)
    );

    tstamp_rdmux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .SEC_W(SEC_W), .MIN_W(MIN_W), .HR_W(HR_W),
        .DAY_W(DAY_W), .MON_W(MON_W), .YR_W(YR_W)
    ) u_rdmux (
        .addr  (addr),
        .state (ctrl_q),
        .stamp (stamp_q),
        .rdata (rdata)
    );

endmodule

// File: rtl/tstamp_checker.sv
module tstamp_checker
    import tstamp_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int TS_W   = 39
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tamper,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              irq_n,
    input ctrl_state_t       st,
    input logic [TS_W-1:0]   stamp,
    input logic [TS_W-1:0]   cal
);

    wire unused_wdata = ^wdata;
    logic accept;
    assign accept = tamper && !st.off && (!st.keep || (!st.flag_a && !st.flag_b));

    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> stamp == $past(cal));

    a_r3_flags: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> st.flag_a && st.flag_b);

    a_r5_first_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tamper && st.keep && (st.flag_a || st.flag_b) |=> $stable(stamp));

    a_r6_off_stamp: assert property (@(posedge clk) disable iff (!rst_n)
        tamper && st.off |=> $stable(stamp));

    a_r6_off_flag: assert property (@(posedge clk) disable iff (!rst_n)
        st.off && !st.flag_a |=> !st.flag_a);

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == ADDR_W'(ADDR_CTL_A) && !wdata[BIT_FLAG_A] && !accept
        |=> !st.flag_a);

    a_r8_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> st.ie && (st.flag_a || st.flag_b));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(stamp));

endmodule

bind tamper_stamp tstamp_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TS_W(TS_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tamper (tamper),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .irq_n  (irq_n),
    .st     (ctrl_q),
    .stamp  (stamp_q),
    .cal    (cal_vec)
);

// File: tb/test_tamper_stamp.sv
`timescale 1ns/1ps
module test_tamper_stamp;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tamper = 1'b0;
    logic [6:0] cal_sec = '0;
    logic [6:0] cal_min = '0;
    logic [5:0] cal_hour = '0;
    logic [5:0] cal_day = '0;
    logic [4:0] cal_mon = '0;
    logic [7:0] cal_year = '0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_n;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    tamper_stamp i_tamper_stamp (
        .clk(clk), .rst_n(rst_n), .tamper(tamper),
        .cal_sec(cal_sec), .cal_min(cal_min), .cal_hour(cal_hour),
        .cal_day(cal_day), .cal_mon(cal_mon), .cal_year(cal_year),
        .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_n(irq_n)
    );

    // bytes of cal/exp: [7:0] sec ... [47:40] year
    typedef struct packed {
        logic        keep;
        logic        off;
        logic        clr;
        logic [47:0] cal;
        logic [47:0] exp;
        logic        flag;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b1, 48'h99_12_31_23_59_59, 48'h99_12_31_23_59_59, 1'b1},
        '{1'b0, 1'b0, 1'b0, 48'h00_01_01_00_00_00, 48'h00_01_01_00_00_00, 1'b1},
        '{1'b1, 1'b0, 1'b0, 48'h24_06_15_05_34_12, 48'h00_01_01_00_00_00, 1'b1},
        '{1'b1, 1'b0, 1'b1, 48'h24_06_15_05_34_12, 48'h24_06_15_05_34_12, 1'b1},
        '{1'b1, 1'b0, 1'b0, 48'h25_07_20_11_10_45, 48'h24_06_15_05_34_12, 1'b1},
        '{1'b0, 1'b1, 1'b1, 48'h25_07_20_11_10_45, 48'h24_06_15_05_34_12, 1'b0},
        '{1'b0, 1'b0, 1'b0, 48'h25_07_20_11_10_45, 48'h25_07_20_11_10_45, 1'b1}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic set_cal(input logic [47:0] c);
        cal_sec  = c[6:0];
        cal_min  = c[14:8];
        cal_hour = c[21:16];
        cal_day  = c[29:24];
        cal_mon  = c[36:32];
        cal_year = c[47:40];
    endtask

    task automatic pulse(input logic [47:0] c);
        @(negedge clk);
        set_cal(c);
        tamper = 1'b1;
        @(negedge clk);
        tamper = 1'b0;
    endtask

    task automatic check_fields(input string req, input logic [47:0] e);
        logic [7:0] d;
        for (int f = 0; f < 6; f++) begin
            rd(4'(3 + f), d);
            chk(req, d, e[8*f +: 8]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 9; a++) begin
            rd(4'(a), d);
            chk("R1 reset reg", d, 8'h00);
        end
        chk("R1 irq_n", {7'b0, irq_n}, 8'h01);

        wr(4'd1, 8'h04);    // interrupt enable

        // table: R2 R3 R4 R5 R6 R8
        for (int v = 0; v < NV; v++) begin
            wr(4'd2, {VECS[v].keep, VECS[v].off, 6'b0});
            if (VECS[v].clr) begin
                wr(4'd0, 8'h00);
                wr(4'd1, 8'h04);
            end
            pulse(VECS[v].cal);
            check_fields("R2/R4/R5/R6 fields", VECS[v].exp);
            rd(4'd0, d);
            chk("R3/R6 flag A", d, VECS[v].flag ? 8'h10 : 8'h00);
            rd(4'd1, d);
            chk("R3/R6 flag B", d, VECS[v].flag ? 8'h24 : 8'h04);
            chk("R8 irq_n table", {7'b0, irq_n}, {7'b0, !VECS[v].flag});
        end

        // R8: enable off masks the interrupt; writing 1 keeps flag B (R7)
        wr(4'd1, 8'h20);
        chk("R8 irq masked", {7'b0, irq_n}, 8'h01);
        rd(4'd1, d);
        chk("R7 write one keeps flag", d, 8'h20);
        wr(4'd1, 8'h24);
        chk("R8 irq asserted", {7'b0, irq_n}, 8'h00);

        // R9: capture registers read-only, unused bits and addresses read 0
        wr(4'd3, 8'h77);
        rd(4'd3, d);
        chk("R9 read only", d, 8'h45);
        wr(4'd2, 8'h3F);
        rd(4'd2, d);
        chk("R9 unused bits", d, 8'h00);
        rd(4'd9, d);
        chk("R9 unused addr", d, 8'h00);

        // R5: one flag still set blocks capture in first-event mode
        wr(4'd2, 8'h80);
        wr(4'd0, 8'h00);
        pulse(48'h06_05_04_03_02_01);
        rd(4'd3, d);
        chk("R5 partial clear holds", d, 8'h45);
        rd(4'd0, d);
        chk("R5 flag A not set when ignored", d, 8'h00);
        wr(4'd1, 8'h04);
        pulse(48'h06_05_04_03_02_01);
        check_fields("R5 capture after clear", 48'h06_05_04_03_02_01);

        // R7: event in the same cycle as a clearing write wins
        wr(4'd2, 8'h00);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'd0; wdata = 8'h00;
        set_cal(48'h23_04_05_06_07_33);
        tamper = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tamper = 1'b0;
        rd(4'd0, d);
        chk("R7 event beats clear", d, 8'h10);
        rd(4'd3, d);
        chk("R7 capture same cycle", d, 8'h33);

        // R1: reset again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(4'd3, d);
        chk("R1 reset clears capture", d, 8'h00);
        chk("R1 irq_n after reset", {7'b0, irq_n}, 8'h01);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule